// File: doc/BRIEF.md
# Row Phase Timer with Display Clock Divider

This block turns a fast input clock into a slower display-clock enable, using a divide ratio chosen by a 4-bit code. On that enable it times the two segment-drive phases of each display row. The first phase (discharge) drains the charge that the previous pixel data left behind. The second phase (charge) drives the pixel toward its new level. Discharge always comes first. The block reports which phase is running and raises a one-cycle row-done pulse that a row scanner can use to step to the next line.

Each phase length comes from its own 4-bit code. The discharge code counts in pairs of display clocks, and codes below five are raised to five. The charge code counts in single display clocks, and codes below three are raised to three. All three codes are captured together at the moment a row begins, so a code written part-way through a row takes effect on the following row. While `enable` stays high, rows follow one another with no gap. Dropping `enable` stops the sequence at the next clock edge.

The controller has three states. IDLE goes to DISCHARGE when `enable` is high. DISCHARGE goes to CHARGE on its last display clock. CHARGE goes back to DISCHARGE on its last display clock when `enable` is still high; this is the restart. Any state goes to IDLE at the next edge when `enable` is low.

Top module: `row_phase_timer`

## Requirements
- R1: While `rst_n` is low, and after its release with `enable` low, `phase` is 0, and `dclk_en` and `row_done` are 0.
- R2: While a row is running, `dclk_en` is high for exactly one input clock in every `div_code`+1 input clocks, counted from the first cycle of the row. A code of 0 gives a pulse every clock.
- R3: DISCHARGE lasts 2·u display clocks. Here u is `ph1_code` when that code is in 5..14, u is 5 for codes 0..4, and u is 31 for code 15.
- R4: CHARGE lasts max(`ph2_code`, 3) display clocks.
- R5: The `phase` encoding is 0 for IDLE, 1 for DISCHARGE and 2 for CHARGE; the value 3 never appears. A row entered from IDLE shows phase 1 in the first cycle after the edge that samples `enable` high, then phase 2, and never goes from 0 straight to 2.
- R6: `row_done` is high for exactly one input clock. That clock is the last cycle of CHARGE, and `dclk_en` is also high in it.
- R7: When `enable` is high, the cycle after `row_done` starts a new DISCHARGE phase (phase 1).
- R8: `div_code`, `ph1_code` and `ph2_code` are sampled only on the edge that starts a row. A change during a row has no effect on that row and governs the next one.
- R9: From the edge after `enable` is sampled low, `phase` is 0 and `dclk_en` and `row_done` stay 0, even when a row was in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run row sequences while high |
| div_code | input | 4 | Display clock divide code, ratio = code+1 |
| ph1_code | input | 4 | Discharge length code, units of two display clocks |
| ph2_code | input | 4 | Charge length code, in display clocks |
| dclk_en | output | 1 | Display clock enable pulse |
| phase | output | 2 | 0 idle, 1 discharge, 2 charge |
| row_done | output | 1 | One-cycle pulse on the last cycle of charge |

## Verification
Each corner case is tested at the ports, cycle by cycle:
- **Divide codes.** The bench tries every divide code. A divider that is off by one from `div_code`+1 shifts every `dclk_en` pulse and changes every phase length.
- **Phase-length codes.** It tries every pair of phase codes. This covers both clamp floors, the code-15 special case of 62 display clocks, and a phase that ends one unit early or late.
- **Mid-row code changes.** It changes the codes during a row. A design that samples the codes every cycle instead of at the row start would lengthen or cut short the running row.
- **Restart and abort.** It holds `enable` high across rows to check that the restart comes with no gap. It also drops `enable` in the middle of a row to check for an immediate return to idle with no stray pulses.

// File: rtl/row_phase_pkg.sv
package row_phase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DISCHARGE = 2'd1,
        ST_CHARGE    = 2'd2
    } row_state_t;

endpackage

// File: rtl/dclk_divider.sv
module dclk_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Free-running modulo counter, held at zero while not running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == ratio_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == ratio_m1);

endmodule

// File: rtl/phase_length_map.sv
module phase_length_map #(
    parameter int CODE_W       = 4,
    parameter int P1_FLOOR     = 5,
    parameter int P1_TOP_UNITS = 31,
    parameter int P2_FLOOR     = 3,
    parameter int LEN_W        = 6
) (
    input  logic [CODE_W-1:0] ph1_code,
    input  logic [CODE_W-1:0] ph2_code,
    output logic [LEN_W-1:0]  len1,
    output logic [LEN_W-1:0]  len2
);
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

    logic [LEN_W-1:0] units1;

    // Discharge: counted in pairs of display clocks
    always_comb begin
        if (ph1_code == CODE_TOP) begin
            units1 = LEN_W'(P1_TOP_UNITS);
        end else if (ph1_code < CODE_W'(P1_FLOOR)) begin
            units1 = LEN_W'(P1_FLOOR);
        end else begin
            units1 = LEN_W'(ph1_code);
        end
        len1 = units1 << 1;
    end

    // Charge: counted in single display clocks
    always_comb begin
        if (ph2_code < CODE_W'(P2_FLOOR)) begin
            len2 = LEN_W'(P2_FLOOR);
        end else begin
            len2 = LEN_W'(ph2_code);
        end
    end

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [LEN_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + LEN_W'(1);
        end
    end

endmodule

// File: rtl/row_phase_timer.sv
module row_phase_timer
    import row_phase_pkg::*;
#(
    parameter int CODE_W       = 4,
    parameter int P1_FLOOR     = 5,
    parameter int P1_TOP_UNITS = 31,
    parameter int P2_FLOOR     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] div_code,
    input  logic [CODE_W-1:0] ph1_code,
    input  logic [CODE_W-1:0] ph2_code,
    output logic              dclk_en,
    output logic [1:0]        phase,
    output logic              row_done
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int LEN1_MAX = 2 * P1_TOP_UNITS;
    localparam int LEN_MAX  = (LEN1_MAX > CODE_MAX) ? LEN1_MAX : CODE_MAX;
    localparam int LEN_W    = $clog2(LEN_MAX + 1);

    row_state_t state_q, state_d;

    logic [CODE_W-1:0] div_lat_q;
    logic [LEN_W-1:0]  len1_lat_q, len2_lat_q;
    logic [LEN_W-1:0]  len1_w, len2_w;
    logic [LEN_W-1:0]  ph_cnt;
    logic [LEN_W-1:0]  target;
    logic              tick;
    logic              last_w;
    logic              start_row;
    logic              cnt_clear;

    phase_length_map #(
        .CODE_W      (CODE_W),
        .P1_FLOOR    (P1_FLOOR),
        .P1_TOP_UNITS(P1_TOP_UNITS),
        .P2_FLOOR    (P2_FLOOR),
        .LEN_W       (LEN_W)
    ) u_map (
        .ph1_code(ph1_code),
        .ph2_code(ph2_code),
        .len1    (len1_w),
        .len2    (len2_w)
    );

    dclk_divider #(
        .DIV_W(CODE_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != ST_IDLE),
        .ratio_m1(div_lat_q),
        .tick    (tick)
    );

    phase_counter #(
        .LEN_W(LEN_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .step (tick),
        .count(ph_cnt)
    );

    // Completion of the phase currently running
    always_comb begin
        target = (state_q == ST_CHARGE) ? len2_lat_q : len1_lat_q;
        last_w = tick && (ph_cnt == target - LEN_W'(1));
    end

    // A row begins on leaving IDLE or on a restart after CHARGE
    always_comb begin
        start_row = enable &&
                    ((state_q == ST_IDLE) ||
                     (state_q == ST_CHARGE && last_w));
        cnt_clear = !enable || start_row ||
                    (state_q == ST_DISCHARGE && last_w);
    end

    // Row configuration captured only at row start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lat_q  <= '0;
            len1_lat_q <= LEN_W'(2 * P1_FLOOR);
            len2_lat_q <= LEN_W'(P2_FLOOR);
        end else if (start_row) begin
            div_lat_q  <= div_code;
            len1_lat_q <= len1_w;
            len2_lat_q <= len2_w;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_DISCHARGE;
            end
            ST_DISCHARGE: begin
                if (!enable)     state_d = ST_IDLE;
                else if (last_w) state_d = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (!enable)     state_d = ST_IDLE;
                else if (last_w) state_d = ST_DISCHARGE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        phase    = state_q;
        dclk_en  = tick;
        row_done = 1'b0;
        unique case (state_q)
            ST_IDLE:      row_done = 1'b0;
            ST_DISCHARGE: row_done = 1'b0;
            ST_CHARGE:    row_done = last_w;
            default:      row_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/row_phase_timer_checker.sv
module row_phase_timer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       dclk_en,
    input logic [1:0] phase,
    input logic       row_done
);
    assert_legal_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    assert_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> ($past(phase) != 2'd0));

    assert_done_in_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (phase == 2'd2 && dclk_en));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && row_done) |=> (phase == 2'd1));

    assert_tick_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_en |-> (phase != 2'd0));

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase == 2'd0 && !dclk_en && !row_done));

endmodule

bind row_phase_timer row_phase_timer_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .dclk_en (dclk_en),
    .phase   (phase),
    .row_done(row_done)
);

// File: tb/row_phase_timer_test.sv
module row_phase_timer_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic [3:0] div_code, ph1_code, ph2_code;
    logic       dclk_en;
    logic [1:0] phase;
    logic       row_done;
    int         tests = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    row_phase_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_code(div_code),
        .ph1_code(ph1_code),
        .ph2_code(ph2_code),
        .dclk_en (dclk_en),
        .phase   (phase),
        .row_done(row_done)
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int len1_of(int c);
        if (c == 15) return 62;
        if (c < 5) return 10;
        return 2 * c;
    endfunction

    function automatic int len2_of(int c);
        return (c < 3) ? 3 : c;
    endfunction

    task automatic begin_row(int d, int p1, int p2);
        @(negedge clk);
        div_code = 4'(d);
        ph1_code = 4'(p1);
        ph2_code = 4'(p2);
        enable   = 1'b1;
    endtask

    // Follows one row cycle by cycle; optionally rewrites the codes mid-row
    task automatic follow_row(int r, int l1, int l2, bit chg,
                              int nd, int n1, int n2, string req);
        int t;
        t = r * (l1 + l2);
        for (int k = 1; k <= t; k++) begin
            @(posedge clk); #1;
            check(req, "phase", int'(phase), (k <= r * l1) ? 1 : 2);
            check(req, "dclk_en", int'(dclk_en), (k % r == 0) ? 1 : 0);
            check(req, "row_done", int'(row_done), (k == t) ? 1 : 0);
            if (chg && k == 2) begin
                div_code = 4'(nd);
                ph1_code = 4'(n1);
                ph2_code = 4'(n2);
            end
        end
    endtask

    task automatic end_row();
        @(posedge clk); #1;
        check("R7", "phase after row_done", int'(phase), 1);
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk); #1;
        check("R9", "phase after disable", int'(phase), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        enable   = 1'b0;
        div_code = '0;
        ph1_code = '0;
        ph2_code = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "phase in reset", int'(phase), 0);
        check("R1", "dclk_en in reset", int'(dclk_en), 0);
        check("R1", "row_done in reset", int'(row_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check("R1", "phase idle", int'(phase), 0);
            check("R1", "dclk_en idle", int'(dclk_en), 0);
        end

        // R2: every divide code with minimum phase lengths
        for (int d = 0; d < 16; d++) begin
            begin_row(d, 0, 0);
            follow_row(d + 1, 10, 3, 1'b0, 0, 0, 0, "R2");
            end_row();
        end

        // R3 and R4: every pair of phase codes at ratio 1
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                begin_row(0, a, b);
                follow_row(1, len1_of(a), len2_of(b), 1'b0, 0, 0, 0,
                           (b == 0) ? "R3" : "R4");
                end_row();
            end
        end

        // R5: ordering at a non-trivial ratio
        begin_row(3, 7, 9);
        follow_row(4, 14, 9, 1'b0, 0, 0, 0, "R5");
        end_row();

        // R6 and R7: back-to-back rows with enable held
        begin_row(1, 5, 4);
        follow_row(2, 10, 4, 1'b0, 0, 0, 0, "R6");
        follow_row(2, 10, 4, 1'b0, 0, 0, 0, "R7");
        end_row();

        // R8: codes changed mid-row apply only to the next row
        begin_row(0, 6, 5);
        follow_row(1, 12, 5, 1'b1, 2, 8, 10, "R8");
        follow_row(3, 16, 10, 1'b1, 0, 15, 15, "R8");
        follow_row(1, 62, 15, 1'b0, 0, 0, 0, "R8");
        end_row();

        // R9: abort in the middle of a row
        begin_row(2, 9, 9);
        repeat (7) @(posedge clk);
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            check("R9", "phase", int'(phase), 0);
            check("R9", "dclk_en", int'(dclk_en), 0);
            check("R9", "row_done", int'(row_done), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule